// File: doc/BRIEF.md
# Calendar and Time-of-Day Counter

This block keeps the time of day and the calendar. A one-cycle pulse on `tick` marks each elapsed second, and the block moves the stored time forward by one second. It tracks seconds, minutes, hours, day of week, day of month, month and a two-digit year. The February length follows a leap-year rule. An optional daylight-saving rule moves the clock forward one hour in spring and back one hour in autumn.

Software loads any single field through a parallel write port. A second, combinational port returns any field. Two run-time bits choose how values appear on both ports. One picks binary or packed BCD. The other picks 24-hour form or 12-hour form with an afternoon flag. Internally the counters are always held as plain binary in 24-hour form, so changing either bit never corrupts the count.

A hold bit freezes counting while software loads a consistent set of values.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the block holds 00:00:00, day of week 1, day 1, month 1, year 00.
- R2: Each accepted tick adds one second. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R3: Day of week runs from 1 to 7, where 1 is Sunday. It advances at midnight and wraps from 7 back to 1.
- R4: Months 4, 6, 9 and 11 have 30 days, and all other months except February have 31. December wraps to January and advances the year. The year wraps from 99 to 00.
- R5: February has 29 days when the year is divisible by 4, including 00, and 28 days otherwise.
- R6: With `cfg_bin`=1, written and read values are plain binary. With `cfg_bin`=0 they are packed BCD: tens digit in bits 7:4 and units digit in bits 3:0.
- R7: With `cfg_24h`=0, the hour field carries the afternoon flag in bit 7 and the hour 1..12 in bits 6:0. It runs 11 AM, 12 PM, 1 PM, and 11 PM, 12 AM. The flag toggles on the step from 11 to 12.
- R8: With `cfg_dst`=1, on a Sunday (day of week 1) in April with date 1..7, the tick after 01:59:59 gives 03:00:00. Otherwise that tick gives 02:00:00.
- R9: With `cfg_dst`=1, on a Sunday in October with date 25 or later, the tick after 01:59:59 gives 01:00:00 once. The next pass through 01:59:59 on that day proceeds to 02:00:00.
- R10: While `hold`=1, ticks are ignored but writes still take effect. Counting resumes at the first tick after `hold` clears.
- R11: When a write and an accepted tick fall in the same cycle, the written field takes the written value and every other field takes its advanced value.
- R12: The field select on both ports uses 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. A read of select 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| hold | input | 1 | Freezes counting while set |
| cfg_bin | input | 1 | 1 binary, 0 packed BCD on both ports |
| cfg_24h | input | 1 | 1 24-hour, 0 12-hour with afternoon flag |
| cfg_dst | input | 1 | Enables daylight-saving adjustment |
| wr_en | input | 1 | Write strobe for one field |
| wr_sel | input | 3 | Field written |
| wr_data | input | 8 | Value written, in the selected format |
| rd_sel | input | 3 | Field read |
| rd_data | output | 8 | Selected field in the selected format |

## Verification
A software write and a counting step can land in the same clock cycle. The bench provokes this by raising `tick` and `wr_en` together while the seconds sit at 59, so a carry is heading into the minutes being written. It judges the result by reading back all three low fields. The seconds must have wrapped, the minutes must show the written value rather than the carried one, and the hours must be untouched. The daylight-saving jumps are also exercised, because they override the normal carry chain exactly at 01:59:59.

// File: rtl/rtc_cal_pkg.sv
// Shared constants, field encoding, time record and conversion helpers
// for the calendar counter. Assumes values are binary and in range.
package rtc_cal_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 7;
    localparam int SEL_W      = 3;
    localparam int HOUR_IDX   = 2;
    localparam logic [FIELD_W-1:0] SEC_TOP   = 8'd59;
    localparam logic [FIELD_W-1:0] HOUR_TOP  = 8'd23;
    localparam logic [FIELD_W-1:0] DOW_TOP   = 8'd7;
    localparam logic [FIELD_W-1:0] MONTH_TOP = 8'd12;
    localparam logic [FIELD_W-1:0] YEAR_TOP  = 8'd99;

    typedef struct packed {
        logic [FIELD_W-1:0] sec;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] hour;
        logic [FIELD_W-1:0] dow;
        logic [FIELD_W-1:0] date;
        logic [FIELD_W-1:0] month;
        logic [FIELD_W-1:0] year;
    } rtc_time_t;

    // Binary 0..99 to packed two-digit BCD.
    function automatic logic [FIELD_W-1:0] to_bcd(input logic [FIELD_W-1:0] b);
        logic [FIELD_W-1:0] tens;
        logic [FIELD_W-1:0] ones;
        tens = b / 8'd10;
        ones = b % 8'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    // Packed two-digit BCD to binary.
    function automatic logic [FIELD_W-1:0] from_bcd(input logic [FIELD_W-1:0] v);
        return {4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]};
    endfunction

    // Number of days in a month; yl is the year's two low bits.
    function automatic logic [FIELD_W-1:0] month_len(input logic [FIELD_W-1:0] m,
                                                     input logic [1:0] yl);
        if (m == 8'd2)
            return (yl == 2'd0) ? 8'd29 : 8'd28;
        else if (m == 8'd4 || m == 8'd6 || m == 8'd9 || m == 8'd11)
            return 8'd30;
        else
            return 8'd31;
    endfunction
endpackage

// File: rtl/rtc_wr_decode.sv
// Turns a value written by software in the current format (binary or
// BCD, 12- or 24-hour) into the internal binary 24-hour form.
// Assumes software writes legal values.
module rtc_wr_decode
    import rtc_cal_pkg::*;
(
    input  logic                 cfg_bin,
    input  logic                 cfg_24h,
    input  logic [SEL_W-1:0]     sel,
    input  logic [FIELD_W-1:0]   data,
    output logic [FIELD_W-1:0]   value
);
    logic [FIELD_W-1:0] plain;
    logic [FIELD_W-1:0] h12;

    // Decode the value and fold 12-hour hours into 0..23.
    always_comb begin
        plain = cfg_bin ? data : from_bcd(data);
        h12   = cfg_bin ? {1'b0, data[6:0]} : from_bcd({1'b0, data[6:0]});
        value = plain;
        if (sel == SEL_W'(HOUR_IDX) && !cfg_24h)
            value = ((h12 == 8'd12) ? 8'd0 : h12) + (data[7] ? 8'd12 : 8'd0);
    end
endmodule

// File: rtl/rtc_advance.sv
// Next-second calculation on the binary 24-hour time record, including
// month lengths, leap years and the daylight-saving jumps. Pure logic.
// Assumes the current record is in range; dow 1 is Sunday.
module rtc_advance
    import rtc_cal_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      dst_en,
    input  logic      fb_done,
    output rtc_time_t nxt,
    output logic      fb_set,
    output logic      day_roll
);
    logic               at_0159;
    logic               spring;
    logic               fall;
    logic [FIELD_W-1:0] mlen;

    // Detect the two daylight-saving instants.
    always_comb begin
        at_0159 = (cur.hour == 8'd1) && (cur.min == SEC_TOP) && (cur.sec == SEC_TOP);
        spring  = dst_en && cur.month == 8'd4 && cur.dow == 8'd1 &&
                  cur.date <= 8'd7 && at_0159;
        fall    = dst_en && cur.month == 8'd10 && cur.dow == 8'd1 &&
                  cur.date >= 8'd25 && at_0159 && !fb_done;
        mlen    = month_len(cur.month, cur.year[1:0]);
    end

    // Carry chain from seconds up to year, with DST overrides first.
    always_comb begin
        nxt      = cur;
        fb_set   = 1'b0;
        day_roll = 1'b0;
        if (spring) begin
            nxt.hour = 8'd3;
            nxt.min  = 8'd0;
            nxt.sec  = 8'd0;
        end else if (fall) begin
            nxt.hour = 8'd1;
            nxt.min  = 8'd0;
            nxt.sec  = 8'd0;
            fb_set   = 1'b1;
        end else if (cur.sec != SEC_TOP) begin
            nxt.sec = cur.sec + 8'd1;
        end else begin
            nxt.sec = 8'd0;
            if (cur.min != SEC_TOP) begin
                nxt.min = cur.min + 8'd1;
            end else begin
                nxt.min = 8'd0;
                if (cur.hour != HOUR_TOP) begin
                    nxt.hour = cur.hour + 8'd1;
                end else begin
                    nxt.hour = 8'd0;
                    day_roll = 1'b1;
                    nxt.dow  = (cur.dow == DOW_TOP) ? 8'd1 : cur.dow + 8'd1;
                    if (cur.date != mlen) begin
                        nxt.date = cur.date + 8'd1;
                    end else begin
                        nxt.date = 8'd1;
                        if (cur.month != MONTH_TOP) begin
                            nxt.month = cur.month + 8'd1;
                        end else begin
                            nxt.month = 8'd1;
                            nxt.year  = (cur.year == YEAR_TOP) ? 8'd0 : cur.year + 8'd1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rtc_rd_format.sv
// Presents one field of the binary 24-hour record in the selected
// format; the hour gains the afternoon flag in 12-hour form.
// Assumes the record is in range.
module rtc_rd_format
    import rtc_cal_pkg::*;
(
    input  rtc_time_t            cur,
    input  logic                 cfg_bin,
    input  logic                 cfg_24h,
    input  logic [SEL_W-1:0]     rd_sel,
    output logic [FIELD_W-1:0]   rd_data
);
    logic [FIELD_W-1:0] fld  [NUM_FIELDS];
    logic [FIELD_W-1:0] conv [NUM_FIELDS];

    // Lay the record out in select order.
    always_comb begin
        fld[0] = cur.sec;
        fld[1] = cur.min;
        fld[2] = cur.hour;
        fld[3] = cur.dow;
        fld[4] = cur.date;
        fld[5] = cur.month;
        fld[6] = cur.year;
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        if (i == HOUR_IDX) begin : g_hour
            logic               pm;
            logic [FIELD_W-1:0] h12;
            logic [FIELD_W-1:0] enc;
            // Fold 0..23 into 1..12 plus flag, then encode.
            always_comb begin
                pm  = fld[i] >= 8'd12;
                h12 = (fld[i] == 8'd0) ? 8'd12 :
                      (fld[i] > 8'd12) ? fld[i] - 8'd12 : fld[i];
                if (cfg_24h) begin
                    enc     = cfg_bin ? fld[i] : to_bcd(fld[i]);
                    conv[i] = enc;
                end else begin
                    enc     = cfg_bin ? h12 : to_bcd(h12);
                    conv[i] = {pm, 7'd0} | enc;
                end
            end
        end else begin : g_plain
            // Plain binary or BCD encoding.
            always_comb conv[i] = cfg_bin ? fld[i] : to_bcd(fld[i]);
        end
    end

    // Select the requested field; unused codes read zero.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_FIELDS; k++)
            if (rd_sel == SEL_W'(k)) rd_data = conv[k];
    end
endmodule

// File: rtl/rtc_calendar_core.sv
// Top of the calendar counter: holds the binary time record, steps it on
// accepted ticks, applies software writes and returns formatted reads.
// Assumes tick is a single-cycle pulse synchronous to clk.
module rtc_calendar_core
    import rtc_cal_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 hold,
    input  logic                 cfg_bin,
    input  logic                 cfg_24h,
    input  logic                 cfg_dst,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [FIELD_W-1:0]   wr_data,
    input  logic [SEL_W-1:0]     rd_sel,
    output logic [FIELD_W-1:0]   rd_data
);
    localparam rtc_time_t RESET_TIME = '{sec: 8'd0, min: 8'd0, hour: 8'd0,
                                         dow: 8'd1, date: 8'd1, month: 8'd1,
                                         year: 8'd0};

    rtc_time_t          cur_q;
    rtc_time_t          adv;
    rtc_time_t          cur_d;
    logic               fb_q;
    logic               fb_set;
    logic               day_roll;
    logic               step;
    logic [FIELD_W-1:0] wr_value;

    assign step = tick && !hold;

    rtc_wr_decode u_wr (
        .cfg_bin (cfg_bin),
        .cfg_24h (cfg_24h),
        .sel     (wr_sel),
        .data    (wr_data),
        .value   (wr_value)
    );

    rtc_advance u_adv (
        .cur      (cur_q),
        .dst_en   (cfg_dst),
        .fb_done  (fb_q),
        .nxt      (adv),
        .fb_set   (fb_set),
        .day_roll (day_roll)
    );

    rtc_rd_format u_rd (
        .cur     (cur_q),
        .cfg_bin (cfg_bin),
        .cfg_24h (cfg_24h),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

    // Merge the step with a same-cycle write; the write wins its field.
    always_comb begin
        cur_d = step ? adv : cur_q;
        if (wr_en) begin
            case (wr_sel)
                3'd0:    cur_d.sec   = wr_value;
                3'd1:    cur_d.min   = wr_value;
                3'd2:    cur_d.hour  = wr_value;
                3'd3:    cur_d.dow   = wr_value;
                3'd4:    cur_d.date  = wr_value;
                3'd5:    cur_d.month = wr_value;
                3'd6:    cur_d.year  = wr_value;
                default: ;
            endcase
        end
    end

    // Time record register.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= RESET_TIME;
        else        cur_q <= cur_d;
    end

    // Remembers that the autumn hour has already been repeated today.
    always_ff @(posedge clk) begin
        if (!rst_n)                 fb_q <= 1'b0;
        else if (step && fb_set)    fb_q <= 1'b1;
        else if (step && day_roll)  fb_q <= 1'b0;
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
// Property checker for the calendar counter, bound to the top module.
// Observes the strobes and the internal time record.
module rtc_calendar_chk
    import rtc_cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      hold,
    input  logic      wr_en,
    input  rtc_time_t cur
);
    // R10
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !wr_en) |=> $stable(cur));

    // R2
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(cur));

    // R2
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hold && !wr_en && cur.sec < SEC_TOP) |=>
        (cur.sec == $past(cur.sec) + 8'd1));

    // R3
    midnight_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hold && !wr_en && cur.hour == HOUR_TOP &&
         cur.min == SEC_TOP && cur.sec == SEC_TOP) |=>
        (cur.hour == 8'd0 && cur.dow != $past(cur.dow)));

    // R3
    dow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.dow >= 8'd1 && cur.dow <= DOW_TOP));

    // R4
    date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.date >= 8'd1 && cur.date <= 8'd31));
endmodule

bind rtc_calendar_core rtc_calendar_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .hold  (hold),
    .wr_en (wr_en),
    .cur   (cur_q)
);

// File: tb/rtc_calendar_core_tb.sv
// Directed bench for the calendar counter: one task per scenario.
module rtc_calendar_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       hold = 1'b0;
    logic       cfg_bin = 1'b1;
    logic       cfg_24h = 1'b1;
    logic       cfg_dst = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [2:0] rd_sel = 3'd0;
    logic [7:0] rd_data;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rtc_calendar_core u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hold(hold),
        .cfg_bin(cfg_bin), .cfg_24h(cfg_24h), .cfg_dst(cfg_dst),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic chk(input logic [2:0] sel, input logic [7:0] exp, input string req);
        rd_sel = sel;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s field %0d: actual %h expected %h", req, sel, rd_data, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_all(input logic [7:0] y, mo, d, w, h, mi, s);
        wr(3'd6, y); wr(3'd5, mo); wr(3'd4, d); wr(3'd3, w);
        wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
    endtask

    task automatic t_reset();
        chk(0, 8'd0, "R1"); chk(1, 8'd0, "R1"); chk(2, 8'd0, "R1");
        chk(3, 8'd1, "R1"); chk(4, 8'd1, "R1"); chk(5, 8'd1, "R1");
        chk(6, 8'd0, "R1"); chk(7, 8'd0, "R12");
    endtask

    task automatic t_bin_rollover();
        set_all(8'd99, 8'd12, 8'd31, 8'd7, 8'd23, 8'd59, 8'd59);
        do_tick();
        chk(0, 8'd0, "R2"); chk(1, 8'd0, "R2"); chk(2, 8'd0, "R2");
        chk(3, 8'd1, "R3"); chk(4, 8'd1, "R4"); chk(5, 8'd1, "R4");
        chk(6, 8'd0, "R4");
        do_tick();
        chk(0, 8'd1, "R2");
    endtask

    task automatic t_bcd();
        cfg_bin = 1'b0;
        wr(3'd2, 8'h19); wr(3'd1, 8'h59); wr(3'd0, 8'h58);
        do_tick();
        chk(0, 8'h59, "R6");
        do_tick();
        chk(0, 8'h00, "R6"); chk(1, 8'h00, "R6"); chk(2, 8'h20, "R6");
        cfg_bin = 1'b1;
        chk(2, 8'd20, "R6");
    endtask

    task automatic t_leap();
        set_all(8'd24, 8'd2, 8'd28, 8'd3, 8'd23, 8'd59, 8'd59);
        do_tick();
        chk(4, 8'd29, "R5"); chk(5, 8'd2, "R5");
        wr(3'd2, 8'd23); wr(3'd1, 8'd59); wr(3'd0, 8'd59);
        do_tick();
        chk(4, 8'd1, "R5"); chk(5, 8'd3, "R5");
        set_all(8'd23, 8'd2, 8'd28, 8'd3, 8'd23, 8'd59, 8'd59);
        do_tick();
        chk(4, 8'd1, "R5"); chk(5, 8'd3, "R5");
        set_all(8'd0, 8'd2, 8'd28, 8'd3, 8'd23, 8'd59, 8'd59);
        do_tick();
        chk(4, 8'd29, "R5");
    endtask

    task automatic t_month_len();
        set_all(8'd23, 8'd4, 8'd30, 8'd2, 8'd23, 8'd59, 8'd59);
        do_tick();
        chk(4, 8'd1, "R4"); chk(5, 8'd5, "R4"); chk(3, 8'd3, "R3");
        set_all(8'd23, 8'd7, 8'd30, 8'd2, 8'd23, 8'd59, 8'd59);
        do_tick();
        chk(4, 8'd31, "R4"); chk(5, 8'd7, "R4");
    endtask

    task automatic t_12h();
        set_all(8'd23, 8'd5, 8'd10, 8'd2, 8'd11, 8'd59, 8'd59);
        cfg_24h = 1'b0;
        chk(2, 8'h0B, "R7");
        do_tick();
        chk(2, 8'h8C, "R7");
        wr(3'd1, 8'd59); wr(3'd0, 8'd59);
        do_tick();
        chk(2, 8'h81, "R7");
        wr(3'd2, 8'h8B); wr(3'd1, 8'd59); wr(3'd0, 8'd59);
        do_tick();
        chk(2, 8'h0C, "R7"); chk(4, 8'd11, "R7");
        cfg_bin = 1'b0;
        wr(3'd2, 8'h11); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        do_tick();
        chk(2, 8'h92, "R7");
        cfg_bin = 1'b1; cfg_24h = 1'b1;
        chk(2, 8'd12, "R7");
    endtask

    task automatic t_dst_entry();
        cfg_dst = 1'b1;
        set_all(8'd23, 8'd4, 8'd3, 8'd1, 8'd1, 8'd59, 8'd59);
        do_tick();
        chk(2, 8'd3, "R8"); chk(1, 8'd0, "R8"); chk(0, 8'd0, "R8");
        set_all(8'd23, 8'd4, 8'd10, 8'd1, 8'd1, 8'd59, 8'd59);
        do_tick();
        chk(2, 8'd2, "R8");
        cfg_dst = 1'b0;
        set_all(8'd23, 8'd4, 8'd3, 8'd1, 8'd1, 8'd59, 8'd59);
        do_tick();
        chk(2, 8'd2, "R8");
    endtask

    task automatic t_dst_exit();
        cfg_dst = 1'b1;
        set_all(8'd23, 8'd10, 8'd27, 8'd1, 8'd1, 8'd59, 8'd59);
        do_tick();
        chk(2, 8'd1, "R9"); chk(1, 8'd0, "R9"); chk(0, 8'd0, "R9");
        wr(3'd1, 8'd59); wr(3'd0, 8'd59);
        do_tick();
        chk(2, 8'd2, "R9"); chk(1, 8'd0, "R9");
        cfg_dst = 1'b0;
    endtask

    task automatic t_hold();
        wr(3'd0, 8'd10);
        hold = 1'b1;
        do_tick();
        chk(0, 8'd10, "R10");
        wr(3'd0, 8'd20);
        chk(0, 8'd20, "R10");
        hold = 1'b0;
        chk(0, 8'd20, "R10");
        do_tick();
        chk(0, 8'd21, "R10");
    endtask

    task automatic t_same_cycle();
        wr(3'd2, 8'd5); wr(3'd1, 8'd10); wr(3'd0, 8'd59);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'd30;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        chk(0, 8'd0, "R11"); chk(1, 8'd30, "R11"); chk(2, 8'd5, "R11");
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bin_rollover();
        t_bcd();
        t_leap();
        t_month_len();
        t_12h();
        t_dst_entry();
        t_dst_exit();
        t_hold();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule